// File: doc/BRIEF.md
# Banked Scratchpad Read Conflict Arbiter

This block accepts one group of parallel read requests, one request per lane, aimed at a scratchpad whose words are spread across 32 banks. Each bank is one 32-bit word wide and can deliver one word per clock. The arbiter finds out which requests can share a cycle. It then issues the group over as few cycles as the bank conflicts allow. In each of those cycles it drives the selected row and an enable for every bank, raises a grant bit for each lane being served, and returns the data word on that lane.

A lane's bank is the low five bits of its word address, and its row within the bank is the remaining upper bits. Lanes that ask for the same word in the same bank are served together. Lanes that ask for different words in the same bank take turns. A new group enters through a valid/ready handshake. The group is captured in full when it is accepted. A one-cycle done pulse closes it.

The bank storage is part of the block and is modelled as a register array. It is loaded at reset with a fixed pattern that is a function of the word address, so every read returns a known value. There is no write path.

Top module: `bank_conflict_arb`

## Requirements
- R1: A lane at word address A uses bank A mod 32 and row A div 32. Whenever a lane is granted, the bank_row_o field of that bank carries the lane's row.
- R2: In every issue cycle, each bank is enabled at most once. The row it serves is the row of the lowest-numbered lane that is still pending on that bank.
- R3: All pending lanes whose word address equals the row picked for their bank are granted in the same cycle, as a broadcast.
- R4: Pending lanes that hit the same bank at different word addresses are granted in separate cycles. The lowest-numbered lane's address is served first.
- R5: When every valid lane hits a different bank, all valid lanes are granted in the first cycle after acceptance, and done follows in the next cycle.
- R6: The number of grant cycles equals the largest count of distinct word addresses requested within any one bank. done_o is high for exactly one cycle, the cycle after the last grant.
- R7: A lane whose valid bit is low when the group is accepted is never granted. Its address does not add issue cycles.
- R8: If no lane is valid, no grant or bank enable occurs, and done_o is high in the cycle right after acceptance.
- R9: req_ready_o is high only when no group is in flight, and it returns high in the cycle after done. While req_ready_o is low, req_valid_i, lane_vld_i and lane_addr_i are ignored. After reset the block is ready, with no grant, no enable and no done.
- R10: In a lane's grant cycle, its 32-bit field of lane_data_o holds the stored word at its address. The stored word at address A is {~A[15:0], A[15:0]}, with A zero-extended to 16 bits. The field of a lane that is not granted is zero.
- R11: Each valid lane of a group is granted in exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset, also loads the bank contents |
| req_valid_i | input | 1 | A request group is offered |
| req_ready_o | output | 1 | The block can accept a group |
| lane_vld_i | input | 32 | Per-lane request valid, bit n is lane n |
| lane_addr_i | input | 320 | Per-lane 10-bit word address, lane n at bits [10n+9:10n] |
| bank_en_o | output | 32 | Per-bank read enable for this cycle |
| bank_row_o | output | 160 | Per-bank 5-bit row, bank n at bits [5n+4:5n] |
| grant_o | output | 32 | Lanes served in this cycle |
| lane_data_o | output | 1024 | Per-lane read data, lane n at bits [32n+31:32n] |
| done_o | output | 1 | One-cycle pulse that ends a group |

## Verification
The assertions assume that a group is captured only at a handshake. They also assume that no lane's address changes inside the block while the group drains. Nothing is assumed about the inputs while ready is low, because they are ignored then. To show that they are ignored, the stimulus changes the addresses and keeps req_valid_i high through one whole group, then drops it in the done cycle, before ready can rise again. Every other group is offered only when ready is high. The address patterns cover the cases that set the cycle count: distinct banks, a full broadcast, a complete single-bank serialization, mixed conflicts, conflicts that sit only on invalid lanes, and an empty group.

// File: rtl/bca_pkg.sv
package bca_pkg;

    // Fixed bank contents: upper half is the inverted address, lower half the address.
    function automatic logic [31:0] word_value(input logic [31:0] waddr);
        return {~waddr[15:0], waddr[15:0]};
    endfunction

endpackage

// File: rtl/bca_pick.sv
module bca_pick #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned AW    = 10,
    localparam int unsigned BB   = $clog2(BANKS),
    localparam int unsigned RW   = AW - BB
) (
    input  logic [LANES-1:0]    pend_i,
    input  logic [LANES*AW-1:0] addr_i,
    output logic [BANKS-1:0]    bank_en_o,
    output logic [BANKS*RW-1:0] bank_row_o,
    output logic [LANES-1:0]    grant_o
);

    // One selector per bank: the lowest pending lane that maps to it wins.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_comb begin
            bank_en_o[b]              = 1'b0;
            bank_row_o[b*RW +: RW]    = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pend_i[l] && (addr_i[l*AW +: BB] == BB'(b))) begin
                    bank_en_o[b]           = 1'b1;
                    bank_row_o[b*RW +: RW] = addr_i[l*AW + BB +: RW];
                end
            end
        end
    end

    // A lane is served when its bank picked exactly its row.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BB-1:0] bk;
        assign bk = addr_i[l*AW +: BB];
        assign grant_o[l] = pend_i[l] && bank_en_o[bk]
                          && (bank_row_o[bk*RW +: RW] == addr_i[l*AW + BB +: RW]);
    end

endmodule

// File: rtl/bca_store.sv
module bca_store #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned AW    = 10,
    parameter int unsigned DW    = 32,
    localparam int unsigned BB   = $clog2(BANKS),
    localparam int unsigned RW   = AW - BB,
    localparam int unsigned DEPTH = 1 << RW
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [BANKS-1:0]    bank_en_i,
    input  logic [BANKS*RW-1:0] bank_row_i,
    input  logic [LANES-1:0]    grant_i,
    input  logic [LANES*AW-1:0] addr_i,
    output logic [LANES*DW-1:0] lane_data_o
);

    logic [DW-1:0] mem_q [BANKS][DEPTH];
    logic [DW-1:0] bank_rd [BANKS];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int b = 0; b < BANKS; b++) begin
                for (int r = 0; r < DEPTH; r++) begin
                    mem_q[b][r] <= DW'(bca_pkg::word_value(32'(r * BANKS + b)));
                end
            end
        end
    end

    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_rd[b] = bank_en_i[b] ? mem_q[b][bank_row_i[b*RW +: RW]] : '0;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_data_o[l*DW +: DW] = grant_i[l] ? bank_rd[addr_i[l*AW +: BB]] : '0;

        p_lane_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grant_i[l] |-> (lane_data_o[l*DW +: DW]
                            == DW'(bca_pkg::word_value(32'(addr_i[l*AW +: AW])))))
            else $error("lane %0d data mismatch", l);
    end

endmodule

// File: rtl/bank_conflict_arb.sv
module bank_conflict_arb #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned AW    = 10,
    parameter int unsigned DW    = 32,
    localparam int unsigned BB   = $clog2(BANKS),
    localparam int unsigned RW   = AW - BB
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [LANES-1:0]    lane_vld_i,
    input  logic [LANES*AW-1:0] lane_addr_i,
    output logic [BANKS-1:0]    bank_en_o,
    output logic [BANKS*RW-1:0] bank_row_o,
    output logic [LANES-1:0]    grant_o,
    output logic [LANES*DW-1:0] lane_data_o,
    output logic                done_o
);

    typedef struct packed {
        logic                busy;
        logic [LANES-1:0]    pend;
        logic [LANES*AW-1:0] addr;
    } state_t;

    state_t st_d, st_q;

    bca_pick #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) i_pick (
        .pend_i     (st_q.pend),
        .addr_i     (st_q.addr),
        .bank_en_o  (bank_en_o),
        .bank_row_o (bank_row_o),
        .grant_o    (grant_o)
    );

    bca_store #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)) i_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bank_en_i   (bank_en_o),
        .bank_row_i  (bank_row_o),
        .grant_i     (grant_o),
        .addr_i      (st_q.addr),
        .lane_data_o (lane_data_o)
    );

    assign req_ready_o = !st_q.busy;
    assign done_o      = st_q.busy && (st_q.pend == '0);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid_i) begin
                st_d.busy = 1'b1;
                st_d.pend = lane_vld_i;
                st_d.addr = lane_addr_i;
            end
        end else if (st_q.pend == '0) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.pend = st_q.pend & ~grant_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o)
        else $error("done lasted more than one cycle");

    p_progress_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && st_q.pend != '0) |-> (grant_o != '0))
        else $error("issue cycle without any grant");

    p_ready_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> (grant_o == '0 && bank_en_o == '0 && !done_o))
        else $error("activity while idle");

    p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && !done_o) |=> $stable(st_q.addr))
        else $error("captured addresses changed mid-group");

    p_single_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o & ~st_q.pend) == '0)
        else $error("grant to a lane that is not pending");

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        p_row_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grant_o[l] |-> (bank_en_o[st_q.addr[l*AW +: BB]]
                && bank_row_o[st_q.addr[l*AW +: BB]*RW +: RW] == st_q.addr[l*AW + BB +: RW]))
            else $error("lane %0d granted on wrong row", l);
    end

endmodule

// File: tb/test_bank_conflict_arb.sv
module test_bank_conflict_arb;

    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int RW    = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [LANES-1:0]    lane_vld = '0;
    logic [LANES*AW-1:0] lane_addr = '0;
    logic [BANKS-1:0]    bank_en;
    logic [BANKS*RW-1:0] bank_row;
    logic [LANES-1:0]    grant;
    logic [LANES*DW-1:0] lane_data;
    logic                done;

    int checks = 0;
    int errors = 0;
    int ga [LANES];
    logic [LANES-1:0] gv;

    always #2.5 clk = ~clk;

    bank_conflict_arb i_bank_conflict_arb (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .lane_vld_i(lane_vld), .lane_addr_i(lane_addr), .bank_en_o(bank_en),
        .bank_row_o(bank_row), .grant_o(grant), .lane_data_o(lane_data), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive one group from ga/gv and compare the model against the ports each cycle.
    task automatic run_group(input bit junk);
        logic [LANES-1:0] pend;
        logic [LANES-1:0] eg;
        logic [BANKS-1:0] een;
        int pick [BANKS];
        int exp_cyc = 0;
        int cyc = 0;
        for (int b = 0; b < BANKS; b++) begin
            int cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                if (gv[l] && ga[l] % BANKS == b) begin
                    bit seen = 0;
                    for (int j = 0; j < l; j++)
                        if (gv[j] && ga[j] == ga[l]) seen = 1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > exp_cyc) exp_cyc = cnt;
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        lane_vld  = gv;
        for (int l = 0; l < LANES; l++) lane_addr[l*AW +: AW] = AW'(ga[l]);
        @(negedge clk);
        if (junk) begin
            lane_vld  = '1;
            lane_addr = ~lane_addr;
        end else begin
            req_valid = 1'b0;
        end
        pend = gv;
        while (pend != '0 && cyc <= LANES + 2) begin
            een = '0;
            eg  = '0;
            for (int b = 0; b < BANKS; b++) begin
                pick[b] = 0;
                for (int l = 0; l < LANES; l++)
                    if (!een[b] && pend[l] && ga[l] % BANKS == b) begin
                        een[b] = 1'b1;
                        pick[b] = ga[l];
                    end
            end
            for (int l = 0; l < LANES; l++)
                eg[l] = pend[l] && ga[l] == pick[ga[l] % BANKS];
            check(grant == eg, "R3/R4/R7", "grant", longint'(grant), longint'(eg));
            check(bank_en == een, "R2", "bank_en", longint'(bank_en), longint'(een));
            for (int b = 0; b < BANKS; b++)
                if (een[b])
                    check(bank_row[b*RW +: RW] == RW'(pick[b] / BANKS), "R1", "bank_row",
                          longint'(bank_row[b*RW +: RW]), longint'(pick[b] / BANKS));
            for (int l = 0; l < LANES; l++) begin
                logic [31:0] ew;
                ew = eg[l] ? {~16'(ga[l]), 16'(ga[l])} : 32'h0;
                if (lane_data[l*DW +: DW] != ew)
                    check(0, "R10", "lane_data", longint'(lane_data[l*DW +: DW]), longint'(ew));
            end
            check(!done && !req_ready, "R6", "done/ready in issue cycle",
                  longint'({done, req_ready}), 0);
            pend = pend & ~eg;
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R6", "done after last grant", longint'(done), 1);
        check(grant == '0 && bank_en == '0, "R8", "quiet in done cycle",
              longint'(grant), 0);
        check(cyc == exp_cyc, "R6", "issue cycles", longint'(cyc), longint'(exp_cyc));
        @(negedge clk);
        check(!done && req_ready, "R9", "ready after done", longint'({done, req_ready}), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(req_ready && !done && grant == '0 && bank_en == '0, "R9", "reset state",
              longint'({req_ready, done}), 2);

        // R5: distinct banks, mixed rows
        gv = '1;
        for (int l = 0; l < LANES; l++) ga[l] = l + 32 * (l % 7);
        run_group(0);

        // R3: full broadcast of one word
        for (int l = 0; l < LANES; l++) ga[l] = 77;
        run_group(0);

        // R4: every lane on bank 5, different rows, worst case
        for (int l = 0; l < LANES; l++) ga[l] = 5 + 32 * ((31 - l) % 32);
        run_group(0);

        // R3/R4 mixed conflicts and broadcasts
        for (int l = 0; l < LANES; l++) ga[l] = 32 * (l % 4) + (l % 3);
        run_group(0);

        // R7: conflicts only on invalid lanes
        gv = 32'h5555_5555;
        for (int l = 0; l < LANES; l++) ga[l] = (l % 2 == 0) ? l : 32 * l + 1;
        run_group(0);

        // R8: empty group
        gv = '0;
        run_group(0);

        // R9: inputs changed and valid held while busy
        gv = 32'hF0F0_3C3C;
        for (int l = 0; l < LANES; l++) ga[l] = 32 * (l % 5) + (l % 6);
        run_group(1);

        // R11 and general: random groups
        for (int t = 0; t < 20; t++) begin
            gv = $urandom;
            for (int l = 0; l < LANES; l++)
                ga[l] = (t % 2 == 0) ? int'($urandom % 1024) : int'(32 * ($urandom % 4) + $urandom % 8);
            run_group(0);
        end

        finish_run();
    end

endmodule